// File: doc/BRIEF.md
# Serial Channel Interrupt Request Logic

This block keeps the six status flags of one asynchronous serial channel and turns them into request lines. A transmitter and a receiver report events as single-cycle pulses: transmit buffer empty, transmission finished, receive buffer full, parity error and framing error. The block records each event in a flag. Per-source enable bits then gate four interrupt request lines: transmit-empty, transmit-end, receive-full and receive-error. The two data requests, and only those two, are also driven on activation lines toward a transfer controller. An acknowledge from that controller clears the matching data flag with no software action.

Software sees the flags on a status output. It clears a flag by reading it as 1 and then, in a later cycle, writing 0 to that flag's bit. An encoded output names the single request that would be accepted first when several are pending at once. Every source keeps its own request line, so each one can be routed to a separate vector.

Top module: `sio_irq_ctrl`

## Requirements
- R1: Reset state. After reset the status output is 6'b000011. The bit positions are: bit 0 transmit-empty, bit 1 transmit-end, bit 2 receive-full, bit 3 overrun, bit 4 parity error, bit 5 framing error. With all enables low, every request line is 0 and the accepted-source code is 0.
- R2: `irq_txe_o` is 1 exactly when status bit 0 is 1 and `en_txe_i` is 1.
- R3: `irq_tend_o` is 1 exactly when status bit 1 is 1 and `en_tend_i` is 1.
- R4: `irq_rxf_o` is 1 exactly when status bit 2 is 1 and `en_rx_i` is 1.
- R5: `irq_rerr_o` is 1 exactly when at least one of status bits 3, 4 or 5 is 1 and `en_rx_i` is 1.
- R6: `xfer_tx_o` equals `irq_txe_o` and `xfer_rx_o` equals `irq_rxf_o`. The error request and the transmit-end request never drive a transfer activation line.
- R7: `xfer_ack_tx_i` clears status bit 0, and `xfer_ack_rx_i` clears status bit 2, on the next clock edge. No read is needed first.
- R8: A write with `wr_i` high and a 0 in bit n of `wr_data_i` clears flag n only if a `rd_i` cycle earlier than the write saw flag n at 1 since that flag last became 1. A 1 in a bit of the written data never changes that flag.
- R9: A set event for a flag in the same cycle as any clear of that flag (software or acknowledge) leaves the flag at 1.
- R10: While any of status bits 3 to 5 is 1, a receive-full event does not set status bit 2.
- R11: A receive-full event that arrives while status bit 2 is already 1 sets status bit 3 (overrun).
- R12: `src_o` encodes the highest-priority active request: 0 none, 1 receive-error, 2 receive-full, 3 transmit-empty, 4 transmit-end. The priority order is the order of these codes (1 highest). So transmit-empty is reported ahead of transmit-end when both are active.
- R13: If one write clears both status bits 0 and 1, the transmit-end request drops and does not reappear without a new transmit-end event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_txe_i | input | 1 | Transmit buffer empty event pulse |
| ev_tend_i | input | 1 | Transmission finished event pulse |
| ev_rxf_i | input | 1 | Receive buffer full event pulse |
| ev_par_i | input | 1 | Parity error event pulse |
| ev_frm_i | input | 1 | Framing error event pulse |
| en_txe_i | input | 1 | Transmit-empty request enable |
| en_tend_i | input | 1 | Transmit-end request enable |
| en_rx_i | input | 1 | Receive-full and receive-error request enable |
| rd_i | input | 1 | Status read strobe |
| wr_i | input | 1 | Status write strobe |
| wr_data_i | input | 6 | Write data; a 0 bit requests a clear |
| xfer_ack_tx_i | input | 1 | Transfer controller finished a transmit-side move |
| xfer_ack_rx_i | input | 1 | Transfer controller finished a receive-side move |
| status_o | output | 6 | Current flags |
| irq_txe_o | output | 1 | Transmit-empty interrupt request |
| irq_tend_o | output | 1 | Transmit-end interrupt request |
| irq_rxf_o | output | 1 | Receive-full interrupt request |
| irq_rerr_o | output | 1 | Receive-error interrupt request |
| xfer_tx_o | output | 1 | Transfer controller activation, transmit side |
| xfer_rx_o | output | 1 | Transfer controller activation, receive side |
| src_o | output | 3 | Encoded accepted source |

## Verification
Some rules are checked by assertions on every cycle. A set event always wins over a clear. A clear with no earlier read leaves the flag unchanged. Acknowledges clear the data flags. A second receive-full event raises overrun, and a blocked receive-full never sets its flag. The encoder never reports transmit-end while transmit-empty is active. Other behaviour shows only in the bench's ordered scenarios: the reset values, the dropped transmit-end request after a combined clear, the enable gating of each line, and the fact that written ones have no effect.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NFLAG  = 6;
  localparam int F_TXE  = 0;
  localparam int F_TEND = 1;
  localparam int F_RXF  = 2;
  localparam int F_OVR  = 3;
  localparam int F_PER  = 4;
  localparam int F_FER  = 5;
  localparam logic [NFLAG-1:0] FLAG_RST = 6'b000011;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_RERR = 3'd1,
    SRC_RXF  = 3'd2,
    SRC_TXE  = 3'd3,
    SRC_TEND = 3'd4
  } src_e;
endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sio_flag_cell.sv
module sio_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic swclr_i,
  input  logic hwclr_i,
  input  logic rd_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic upd;

  // next state: set beats any clear; software clear needs an earlier read
  always_comb begin
    upd    = set_i | swclr_i | hwclr_i | rd_i;
    flag_d = flag_q;
    if (set_i)                              flag_d = 1'b1;
    else if ((swclr_i && armed_q) || hwclr_i) flag_d = 1'b0;
    armed_d = armed_q;
    if (!flag_d)                armed_d = 1'b0;
    else if (rd_i && flag_q)    armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= RST_VAL;
      armed_q <= 1'b0;
    end else if (upd) begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  assert_clr_needs_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (swclr_i && !armed_q && !set_i && !hwclr_i) |=> (flag_q == $past(flag_q)));

  assert_armed_only_when_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> flag_q);
endmodule

// File: rtl/sio_flag_events.sv
module sio_flag_events
  import sio_irq_pkg::*;
(
  input  logic             ev_txe_i,
  input  logic             ev_tend_i,
  input  logic             ev_rxf_i,
  input  logic             ev_par_i,
  input  logic             ev_frm_i,
  input  logic             ack_tx_i,
  input  logic             ack_rx_i,
  input  logic             wr_i,
  input  logic [NFLAG-1:0] wr_data_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic [NFLAG-1:0] set_o,
  output logic [NFLAG-1:0] swclr_o,
  output logic [NFLAG-1:0] hwclr_o
);
  logic err_any;

  always_comb begin
    err_any        = flags_i[F_OVR] | flags_i[F_PER] | flags_i[F_FER];
    set_o          = '0;
    set_o[F_TXE]   = ev_txe_i;
    set_o[F_TEND]  = ev_tend_i;
    set_o[F_RXF]   = ev_rxf_i & ~err_any;
    set_o[F_OVR]   = ev_rxf_i & flags_i[F_RXF];
    set_o[F_PER]   = ev_par_i;
    set_o[F_FER]   = ev_frm_i;
    swclr_o        = {NFLAG{wr_i}} & ~wr_data_i;
    hwclr_o        = '0;
    hwclr_o[F_TXE] = ack_tx_i;
    hwclr_o[F_RXF] = ack_rx_i;
  end
endmodule

// File: rtl/sio_req_arb.sv
module sio_req_arb
  import sio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flags_i,
  input  logic             en_txe_i,
  input  logic             en_tend_i,
  input  logic             en_rx_i,
  output logic             irq_txe_o,
  output logic             irq_tend_o,
  output logic             irq_rxf_o,
  output logic             irq_rerr_o,
  output logic             xfer_tx_o,
  output logic             xfer_rx_o,
  output logic [2:0]       src_o
);
  src_e src;

  always_comb begin
    irq_txe_o  = flags_i[F_TXE]  & en_txe_i;
    irq_tend_o = flags_i[F_TEND] & en_tend_i;
    irq_rxf_o  = flags_i[F_RXF]  & en_rx_i;
    irq_rerr_o = (flags_i[F_OVR] | flags_i[F_PER] | flags_i[F_FER]) & en_rx_i;
    xfer_tx_o  = irq_txe_o;
    xfer_rx_o  = irq_rxf_o;
    if (irq_rerr_o)      src = SRC_RERR;
    else if (irq_rxf_o)  src = SRC_RXF;
    else if (irq_txe_o)  src = SRC_TXE;
    else if (irq_tend_o) src = SRC_TEND;
    else                 src = SRC_NONE;
  end

  assign src_o = src;

  assert_txe_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txe_o |-> (src_o != SRC_TEND));

  assert_src_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (src_o == SRC_NONE) |-> !(irq_txe_o || irq_tend_o || irq_rxf_o || irq_rerr_o));

  assert_no_xfer_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rerr_o && !flags_i[F_RXF]) |-> !xfer_rx_o);
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_txe_i,
  input  logic             ev_tend_i,
  input  logic             ev_rxf_i,
  input  logic             ev_par_i,
  input  logic             ev_frm_i,
  input  logic             en_txe_i,
  input  logic             en_tend_i,
  input  logic             en_rx_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [NFLAG-1:0] wr_data_i,
  input  logic             xfer_ack_tx_i,
  input  logic             xfer_ack_rx_i,
  output logic [NFLAG-1:0] status_o,
  output logic             irq_txe_o,
  output logic             irq_tend_o,
  output logic             irq_rxf_o,
  output logic             irq_rerr_o,
  output logic             xfer_tx_o,
  output logic             xfer_rx_o,
  output logic [2:0]       src_o
);
  logic             rst_s_n;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] set_v, swclr_v, hwclr_v;

  sio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_s_n)
  );

  sio_flag_events u_ev (
    .ev_txe_i(ev_txe_i), .ev_tend_i(ev_tend_i), .ev_rxf_i(ev_rxf_i),
    .ev_par_i(ev_par_i), .ev_frm_i(ev_frm_i),
    .ack_tx_i(xfer_ack_tx_i), .ack_rx_i(xfer_ack_rx_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .flags_i(flags),
    .set_o(set_v), .swclr_o(swclr_v), .hwclr_o(hwclr_v)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sio_flag_cell #(.RST_VAL(FLAG_RST[g])) u_cell (
      .clk(clk), .rst_n(rst_s_n),
      .set_i(set_v[g]), .swclr_i(swclr_v[g]), .hwclr_i(hwclr_v[g]),
      .rd_i(rd_i), .flag_o(flags[g])
    );
  end

  sio_req_arb u_arb (
    .clk(clk), .rst_n(rst_s_n), .flags_i(flags),
    .en_txe_i(en_txe_i), .en_tend_i(en_tend_i), .en_rx_i(en_rx_i),
    .irq_txe_o(irq_txe_o), .irq_tend_o(irq_tend_o),
    .irq_rxf_o(irq_rxf_o), .irq_rerr_o(irq_rerr_o),
    .xfer_tx_o(xfer_tx_o), .xfer_rx_o(xfer_rx_o), .src_o(src_o)
  );

  assign status_o = flags;

  assert_ack_clr_tx_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (xfer_ack_tx_i && !ev_txe_i) |=> !status_o[F_TXE]);

  assert_ack_clr_rx_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (xfer_ack_rx_i && !ev_rxf_i) |=> !status_o[F_RXF]);

  assert_overrun_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ev_rxf_i && status_o[F_RXF]) |=> status_o[F_OVR]);

  assert_rx_blocked_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((|status_o[F_FER:F_OVR]) && ev_rxf_i && !status_o[F_RXF]) |=> !status_o[F_RXF]);
endmodule

// File: tb/sio_irq_ctrl_tb_top.sv
module sio_irq_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_txe = 0, ev_tend = 0, ev_rxf = 0, ev_par = 0, ev_frm = 0;
  logic en_txe = 0, en_tend = 0, en_rx = 0;
  logic rd = 0, wr = 0;
  logic [5:0] wr_data = 6'h3f;
  logic ack_tx = 0, ack_rx = 0;
  logic [5:0] status;
  logic irq_txe, irq_tend, irq_rxf, irq_rerr, xfer_tx, xfer_rx;
  logic [2:0] src;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    string      tag;
    logic [5:0] st;
    logic [3:0] irq;   // {rerr, rxf, tend, txe}
    logic [1:0] xf;    // {rx, tx}
    logic [2:0] src;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  sio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_txe_i(ev_txe), .ev_tend_i(ev_tend), .ev_rxf_i(ev_rxf),
    .ev_par_i(ev_par), .ev_frm_i(ev_frm),
    .en_txe_i(en_txe), .en_tend_i(en_tend), .en_rx_i(en_rx),
    .rd_i(rd), .wr_i(wr), .wr_data_i(wr_data),
    .xfer_ack_tx_i(ack_tx), .xfer_ack_rx_i(ack_rx),
    .status_o(status), .irq_txe_o(irq_txe), .irq_tend_o(irq_tend),
    .irq_rxf_o(irq_rxf), .irq_rerr_o(irq_rerr),
    .xfer_tx_o(xfer_tx), .xfer_rx_o(xfer_rx), .src_o(src)
  );

  // expected outputs from the requirement text (R2..R6, R12)
  function automatic exp_t make_exp(string tag, logic [5:0] st);
    exp_t e;
    e.tag    = tag;
    e.st     = st;
    e.irq[0] = st[0] & en_txe;
    e.irq[1] = st[1] & en_tend;
    e.irq[2] = st[2] & en_rx;
    e.irq[3] = (st[3] | st[4] | st[5]) & en_rx;
    e.xf     = {e.irq[2], e.irq[0]};
    if (e.irq[3])      e.src = 3'd1;
    else if (e.irq[2]) e.src = 3'd2;
    else if (e.irq[0]) e.src = 3'd3;
    else if (e.irq[1]) e.src = 3'd4;
    else               e.src = 3'd0;
    return e;
  endfunction

  // driver: stimulus is set beforehand; one clock, drop pulses, push expectation
  task automatic step(string tag, logic [5:0] exp_st);
    @(posedge clk);
    #1;
    ev_txe = 0; ev_tend = 0; ev_rxf = 0; ev_par = 0; ev_frm = 0;
    rd = 0; wr = 0; wr_data = 6'h3f; ack_tx = 0; ack_rx = 0;
    sb_q.push_back(make_exp(tag, exp_st));
  endtask

  task automatic drive_slot();
    @(posedge clk);
    #2;
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [3:0] a_irq;
      e = sb_q.pop_front();
      a_irq = {irq_rerr, irq_rxf, irq_tend, irq_txe};
      n_checks++;
      if (status !== e.st || a_irq !== e.irq || {xfer_rx, xfer_tx} !== e.xf || src !== e.src) begin
        n_fail++;
        $display("FAIL %s: got st=%b irq=%b xf=%b src=%0d, exp st=%b irq=%b xf=%b src=%0d",
                 e.tag, status, a_irq, {xfer_rx, xfer_tx}, src, e.st, e.irq, e.xf, e.src);
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    step("R1 reset state", 6'b000011);
    drive_slot(); en_txe = 1;                       step("R2 R6 txe request", 6'b000011);
    drive_slot(); en_tend = 1;                      step("R3 R12 txe before tend", 6'b000011);
    drive_slot(); wr = 1; wr_data = 6'b111100;      step("R8 clear without read", 6'b000011);
    drive_slot(); rd = 1;                           step("R8 read arms", 6'b000011);
    drive_slot(); wr = 1; wr_data = 6'b111100;      step("R13 joint clear drops tend", 6'b000000);
    drive_slot();                                   step("R13 tend stays dropped", 6'b000000);
    drive_slot(); ev_tend = 1;                      step("R3 tend event", 6'b000010);
    drive_slot(); ev_txe = 1;                       step("R12 txe event", 6'b000011);
    drive_slot(); ack_tx = 1;                       step("R7 tx ack clears", 6'b000010);
    drive_slot(); en_rx = 1; ev_rxf = 1;            step("R4 R6 rx full", 6'b000110);
    drive_slot(); ev_rxf = 1;                       step("R11 R5 overrun", 6'b001110);
    drive_slot(); ack_rx = 1;                       step("R7 rx ack clears", 6'b001010);
    drive_slot(); ev_rxf = 1;                       step("R10 rx blocked by error", 6'b001010);
    drive_slot(); ev_par = 1;                       step("R5 parity error", 6'b011010);
    drive_slot(); rd = 1;                           step("R8 read errors", 6'b011010);
    drive_slot(); wr = 1; wr_data = 6'b100111;      step("R8 clear errors", 6'b000010);
    drive_slot(); rd = 1;                           step("R9 read tend", 6'b000010);
    drive_slot(); wr = 1; wr_data = 6'b111101; ev_tend = 1; step("R9 set beats clear", 6'b000010);
    drive_slot(); en_rx = 0; ev_frm = 1;            step("R5 gated by enable", 6'b100010);
    drive_slot(); rd = 1;                           step("R8 read all", 6'b100010);
    drive_slot(); wr = 1; wr_data = 6'b111111;      step("R8 ones ignored", 6'b100010);
    drive_slot(); ev_txe = 1; ack_tx = 1;           step("R9 set beats ack", 6'b100011);
    drive_slot(); en_txe = 0; en_tend = 0;          step("R1 all lines off", 6'b100011);
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule